// File: doc/BRIEF.md
# Exception Entry Bank Sequencer

This block performs the stack and register side of taking an exception on a processor that keeps a program bank and a data bank alongside its 16-bit program counter. A single start pulse launches an entry for a hardware interrupt, a software break or a signature trap. The block then writes the return frame to the stack one byte at a time, computes the new bank registers, stack pointer and status byte, and finally asks for the vector fetch. For a signature trap it also reports whether the signature byte lies in the reserved upper half.

How the entry behaves depends on a mode input. In native mode the old program bank goes onto the stack ahead of the program counter and status, and the data bank is left as it was. In emulation mode only the program counter and status are saved, and both banks are zeroed. In emulation mode every stack write goes to a fixed page, and the stack pointer wraps inside that page. The stack writes leave the block as a valid/ready stream. A byte is written on each cycle where both signals are high. While ready is low, valid, address and data hold steady. The stack pointer moves only when a byte is accepted.

Top module: `exc_bank_seq`

## Requirements
- R1: A start pulse while idle captures every context input; busy is high from the next cycle through the vector-request cycle and low after it; start pulses while busy are ignored and start no second entry.
- R2: In native mode (mode input 1) the stream carries, in order, the old program bank, PC bits 15:8, PC bits 7:0, the old status byte, at addresses sp, sp-1, sp-2, sp-3 (16-bit arithmetic).
- R3: In emulation mode (mode input 0) the stream carries PC bits 15:8, PC bits 7:0, the old status byte, at addresses {0x01, low byte of sp} counting down in the low byte only, wrapping from 0x00 to 0xFF inside page 0x01.
- R4: While stream valid is high and ready is low, valid, address and data stay unchanged; the entry advances by exactly one byte for each cycle where valid and ready are both high.
- R5: From the vector-request cycle on, the stack pointer output is the captured pointer after all the pushes: sp-4 in native mode, {0x01, low byte minus 3} in emulation mode.
- R6: From the vector-request cycle on, the program bank output is 0x00; the data bank output keeps the captured data bank in native mode and is 0x00 in emulation mode.
- R7: From the vector-request cycle on, the status output is the captured status with bit 3 (decimal) cleared and bit 2 (interrupt disable) set; the pushed status byte is the unmodified captured value.
- R8: Vector request is a single-cycle pulse issued the cycle after the last byte is accepted, with the source code on its side output (0 hardware interrupt, 1 software break, 2 signature trap).
- R9: During the vector-request cycle the reserved flag is high exactly when the source is 2 and signature bit 7 is set (0x80 to 0xFF); signatures 0x00 to 0x7F and other sources leave it low.
- R10: After reset busy, stream valid and vector request are low, and the bank, status and stack pointer outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an exception entry (taken only when idle) |
| src_i | input | 2 | Source: 0 hardware, 1 software break, 2 signature trap |
| native_i | input | 1 | 1 native mode, 0 emulation mode |
| prog_bank_i | input | 8 | Current program bank |
| data_bank_i | input | 8 | Current data bank |
| pc_i | input | 16 | Return program counter |
| status_i | input | 8 | Current status byte |
| sp_i | input | 16 | Current stack pointer |
| sig_i | input | 8 | Signature byte of a signature trap |
| push_valid_o | output | 1 | Stack write available |
| push_ready_i | input | 1 | Memory accepts the stack write |
| push_addr_o | output | 16 | Stack write address |
| push_data_o | output | 8 | Stack write byte |
| prog_bank_o | output | 8 | Program bank after entry |
| data_bank_o | output | 8 | Data bank after entry |
| sp_o | output | 16 | Stack pointer after entry |
| status_o | output | 8 | Status byte after entry |
| vec_req_o | output | 1 | One-cycle vector fetch request |
| vec_src_o | output | 2 | Source code with the vector request |
| sig_reserved_o | output | 1 | Signature lies in the reserved range |
| busy_o | output | 1 | Entry in progress |

## Verification
The checker checks on every cycle that the stream holds steady under back-pressure and that valid never appears while idle. On each vector request it checks that the request lasts one cycle and that the program bank is zero. It also checks that the status has its decimal bit cleared and its disable bit set, that the data bank is zero for an emulation-mode entry, and that the reserved flag appears only with a signature trap. Only the bench's scenarios can show the exact byte order and addresses of native and emulation frames. The same holds for the page wrap, the final stack pointer values, that a start during busy is dropped, and that signatures on each side of 0x80 are classified correctly.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [1:0] {
    SRC_HW  = 2'd0,
    SRC_BRK = 2'd1,
    SRC_SIG = 2'd2,
    SRC_XTR = 2'd3
  } exc_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_VEC  = 2'd2
  } seq_st_e;

  localparam int STAT_DEC = 3;
  localparam int STAT_IRQ_DIS = 2;
endpackage

// File: rtl/exc_frame_mux.sv
module exc_frame_mux #(
  parameter int DW = 8
) (
  input  logic          native,
  input  logic [1:0]    idx,
  input  logic [DW-1:0] bank,
  input  logic [2*DW-1:0] pc,
  input  logic [DW-1:0] stat,
  output logic [DW-1:0] frame_byte_o,
  output logic          last_o
);
  logic [1:0] slot;

  // Emulation frames skip the bank slot, so they start one slot later.
  always_comb begin
    slot = idx + (native ? 2'd0 : 2'd1);
    unique case (slot)
      2'd0:    frame_byte_o = bank;
      2'd1:    frame_byte_o = pc[2*DW-1:DW];
      2'd2:    frame_byte_o = pc[DW-1:0];
      default: frame_byte_o = stat;
    endcase
    last_o = (slot == 2'd3);
  end
endmodule

// File: rtl/exc_stack_addr.sv
module exc_stack_addr #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int PAGE = 1
) (
  input  logic          native,
  input  logic [AW-1:0] sp,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] sp_next_o
);
  localparam int PW = AW - DW;
  localparam logic [PW-1:0] PG = PW'(PAGE);

  logic [DW-1:0] low_dec;

  always_comb begin
    low_dec = sp[DW-1:0] - 1'b1;
    if (native) begin
      addr_o    = sp;
      sp_next_o = sp - 1'b1;
    end else begin
      addr_o    = {PG, sp[DW-1:0]};
      sp_next_o = {PG, low_dec};
    end
  end
endmodule

// File: rtl/exc_ctx_update.sv
module exc_ctx_update
  import exc_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          native,
  input  logic [DW-1:0] stat,
  input  logic [DW-1:0] dbank,
  input  logic [1:0]    src,
  input  logic [DW-1:0] sig,
  output logic [DW-1:0] stat_new_o,
  output logic [DW-1:0] dbank_new_o,
  output logic          sig_rsv_o
);
  always_comb begin
    stat_new_o               = stat;
    stat_new_o[STAT_DEC]     = 1'b0;
    stat_new_o[STAT_IRQ_DIS] = 1'b1;
    dbank_new_o              = native ? dbank : '0;
    sig_rsv_o                = (src == SRC_SIG) && sig[DW-1];
  end
endmodule

// File: rtl/exc_bank_seq.sv
module exc_bank_seq
  import exc_seq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int EMU_PAGE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        src_i,
  input  logic              native_i,
  input  logic [DATA_W-1:0] prog_bank_i,
  input  logic [DATA_W-1:0] data_bank_i,
  input  logic [2*DATA_W-1:0] pc_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [DATA_W-1:0] sig_i,
  output logic              push_valid_o,
  input  logic              push_ready_i,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic [DATA_W-1:0] push_data_o,
  output logic [DATA_W-1:0] prog_bank_o,
  output logic [DATA_W-1:0] data_bank_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [DATA_W-1:0] status_o,
  output logic              vec_req_o,
  output logic [1:0]        vec_src_o,
  output logic              sig_reserved_o,
  output logic              busy_o
);
  seq_st_e st_q;
  logic [1:0]          idx_q;
  logic                native_q;
  logic [DATA_W-1:0]   bank_q, dbank_q, stat_q, sig_q;
  logic [2*DATA_W-1:0] pc_q;
  logic [1:0]          src_q;
  logic [ADDR_W-1:0]   sp_q;

  logic [DATA_W-1:0]   frame_byte;
  logic                frame_last;
  logic [ADDR_W-1:0]   sp_next;
  logic [DATA_W-1:0]   stat_new, dbank_new;
  logic                sig_rsv;
  logic                fire;

  exc_frame_mux #(.DW(DATA_W)) u_frame (
    .native(native_q), .idx(idx_q), .bank(bank_q), .pc(pc_q), .stat(stat_q),
    .frame_byte_o(frame_byte), .last_o(frame_last)
  );

  exc_stack_addr #(.AW(ADDR_W), .DW(DATA_W), .PAGE(EMU_PAGE)) u_addr (
    .native(native_q), .sp(sp_q), .addr_o(push_addr_o), .sp_next_o(sp_next)
  );

  exc_ctx_update #(.DW(DATA_W)) u_ctx (
    .native(native_q), .stat(stat_q), .dbank(dbank_q), .src(src_q), .sig(sig_q),
    .stat_new_o(stat_new), .dbank_new_o(dbank_new), .sig_rsv_o(sig_rsv)
  );

  assign push_valid_o = (st_q == ST_PUSH);
  assign push_data_o  = frame_byte;
  assign fire         = push_valid_o && push_ready_i;
  assign vec_req_o    = (st_q == ST_VEC);
  assign busy_o       = (st_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      native_q <= 1'b0;
      bank_q   <= '0;
      dbank_q  <= '0;
      stat_q   <= '0;
      sig_q    <= '0;
      pc_q     <= '0;
      src_q    <= '0;
      sp_q     <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q     <= ST_PUSH;
          idx_q    <= '0;
          native_q <= native_i;
          bank_q   <= prog_bank_i;
          dbank_q  <= data_bank_i;
          stat_q   <= status_i;
          sig_q    <= sig_i;
          pc_q     <= pc_i;
          src_q    <= src_i;
          sp_q     <= sp_i;
        end
        ST_PUSH: if (fire) begin
          sp_q  <= sp_next;
          idx_q <= idx_q + 1'b1;
          if (frame_last) st_q <= ST_VEC;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Result registers load on the edge that ends the last push.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_bank_o    <= '0;
      data_bank_o    <= '0;
      sp_o           <= '0;
      status_o       <= '0;
      vec_src_o      <= '0;
      sig_reserved_o <= 1'b0;
    end else if (fire && frame_last) begin
      prog_bank_o    <= '0;
      data_bank_o    <= dbank_new;
      sp_o           <= sp_next;
      status_o       <= stat_new;
      vec_src_o      <= src_q;
      sig_reserved_o <= sig_rsv;
    end
  end
endmodule

// File: rtl/exc_bank_seq_chk.sv
module exc_bank_seq_chk #(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          native_q,
  input logic          push_valid,
  input logic          push_ready,
  input logic [AW-1:0] push_addr,
  input logic [DW-1:0] push_data,
  input logic          vec_req,
  input logic [1:0]    vec_src,
  input logic          sig_reserved,
  input logic [DW-1:0] prog_bank,
  input logic [DW-1:0] data_bank,
  input logic [DW-1:0] status
);
  p_hold_under_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && !push_ready |=> push_valid && $stable(push_addr) && $stable(push_data));

  p_no_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !push_valid);

  p_vec_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> busy && !push_valid);

  p_vec_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |=> !vec_req && !busy);

  p_prog_bank_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> prog_bank == '0);

  p_emu_dbank_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req && !native_q |-> data_bank == '0);

  p_status_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> !status[3] && status[2]);

  p_rsv_only_sig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req && sig_reserved |-> vec_src == 2'd2);
endmodule

bind exc_bank_seq exc_bank_seq_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_o), .native_q(native_q),
  .push_valid(push_valid_o), .push_ready(push_ready_i),
  .push_addr(push_addr_o), .push_data(push_data_o),
  .vec_req(vec_req_o), .vec_src(vec_src_o), .sig_reserved(sig_reserved_o),
  .prog_bank(prog_bank_o), .data_bank(data_bank_o), .status(status_o)
);

// File: tb/exc_bank_seq_tb.sv
module exc_bank_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic start_i = 1'b0, native_i = 1'b0, push_ready_i = 1'b0;
  logic [1:0]  src_i = '0;
  logic [7:0]  prog_bank_i = '0, data_bank_i = '0, status_i = '0, sig_i = '0;
  logic [15:0] pc_i = '0, sp_i = '0;
  logic        push_valid_o, vec_req_o, sig_reserved_o, busy_o;
  logic [15:0] push_addr_o, sp_o;
  logic [7:0]  push_data_o, prog_bank_o, data_bank_o, status_o;
  logic [1:0]  vec_src_o;

  exc_bank_seq u_dut (.*);

  int checks = 0;
  int fails = 0;
  logic [23:0] exp_q[$];
  int stall_mode = 0;
  logic [7:0] lfsr = 8'h5A;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Ready pattern, updated away from the sampling edge.
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    push_ready_i = (stall_mode == 0) ? 1'b1 : lfsr[0];
  end

  // Monitor: pop and compare each accepted stack write.
  always @(negedge clk) begin
    if (rst_n && push_valid_o && push_ready_i) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R1 unexpected push actual=%h expected=none", {push_addr_o, push_data_o});
      end else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk("R2/R3 push addr,data", {8'h0, push_addr_o, push_data_o}, {8'h0, e});
      end
    end
  end

  task automatic run_entry(input logic [1:0] src, input logic nat, input logic [7:0] bank,
                           input logic [7:0] dbank, input logic [15:0] pc, input logic [7:0] st,
                           input logic [15:0] sp, input logic [7:0] sig, input bit inject);
    logic [15:0] s;
    logic [7:0] exp_st;
    int guard;
    s = nat ? sp : {8'h01, sp[7:0]};
    if (nat) begin exp_q.push_back({s, bank}); s = s - 1'b1; end
    exp_q.push_back({s, pc[15:8]}); s = nat ? s - 1'b1 : {8'h01, s[7:0] - 8'd1};
    exp_q.push_back({s, pc[7:0]});  s = nat ? s - 1'b1 : {8'h01, s[7:0] - 8'd1};
    exp_q.push_back({s, st});       s = nat ? s - 1'b1 : {8'h01, s[7:0] - 8'd1};
    exp_st = (st & 8'hF7) | 8'h04;
    @(posedge clk); #1;
    src_i = src; native_i = nat; prog_bank_i = bank; data_bank_i = dbank;
    pc_i = pc; status_i = st; sp_i = sp; sig_i = sig; start_i = 1'b1;
    @(posedge clk); #1; start_i = 1'b0;
    chk("R1 busy after start", busy_o, 1);
    if (inject) begin
      @(posedge clk); #1;
      start_i = 1'b1; pc_i = 16'hDEAD; prog_bank_i = 8'hEE; native_i = ~nat; sp_i = 16'h0042;
      @(posedge clk); #1; start_i = 1'b0;
    end
    guard = 0;
    while (!vec_req_o && guard < 200) begin @(negedge clk); guard++; end
    chk("R8 vec_req seen", vec_req_o, 1);
    chk("R8 vec_src", vec_src_o, src);
    chk("R2/R3 all bytes pushed", exp_q.size(), 0);
    chk("R5 sp_o", sp_o, s);
    chk("R6 prog_bank_o", prog_bank_o, 0);
    chk("R6 data_bank_o", data_bank_o, nat ? dbank : 8'h00);
    chk("R7 status_o", status_o, exp_st);
    chk("R9 sig_reserved", sig_reserved_o, (src == 2'd2) && sig[7]);
    chk("R1 busy in vec cycle", busy_o, 1);
    @(negedge clk);
    chk("R8 vec pulse one cycle", vec_req_o, 0);
    chk("R1 busy low after", busy_o, 0);
    @(negedge clk);
    chk("R1 no second entry", {busy_o, push_valid_o}, 0);
    chk("R7 outputs held", status_o, exp_st);
    exp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    @(negedge clk);
    chk("R10 reset busy/valid/vec", {busy_o, push_valid_o, vec_req_o}, 0);
    chk("R10 reset outputs", {prog_bank_o, data_bank_o, status_o}, 0);
    chk("R10 reset sp", sp_o, 0);
    rst_n = 1'b1;
    // native hardware interrupt, no stalls
    run_entry(2'd0, 1'b1, 8'h12, 8'h34, 16'hA1B2, 8'h08, 16'h1FF0, 8'h00, 0);
    // emulation software break, page wrap, with back-pressure (R4)
    stall_mode = 1;
    run_entry(2'd1, 1'b0, 8'h56, 8'h78, 16'hC3D4, 8'hFF, 16'h3301, 8'h00, 0);
    // native signature trap, reserved sig, start during busy ignored
    run_entry(2'd2, 1'b1, 8'h9A, 8'hBC, 16'h0100, 8'h00, 16'h0000, 8'h80, 1);
    // emulation signature trap, user sig 0x7F
    run_entry(2'd2, 1'b0, 8'h01, 8'h02, 16'hFFFF, 8'h0C, 16'h01FF, 8'h7F, 1);
    // hardware source with high signature byte: no reserved flag (R9)
    stall_mode = 0;
    run_entry(2'd0, 1'b0, 8'h11, 8'h22, 16'h1234, 8'h33, 16'h0180, 8'hFF, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule